// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block produces the raster timing for a cathode-ray or flat display from a single dot clock. Two position counters sweep each line and each frame. Compare windows derived from six timing registers turn the counter values into horizontal sync, vertical sync, a blanking flag and a display-enable strobe. The current pixel coordinates are also driven out for a downstream pixel pipeline. Nothing here fetches pixel data or makes the dot clock.

Software sets the block up through a simple 32-bit register bus that is guarded by a key register. Each timing register holds two positions for one phase, and each position is stored as its value minus one. Writes to the timing registers land in a staging copy. The counters switch to the staged copy only at the start of a frame, so a mode change never tears the frame on screen. The two sync outputs and the DAC enable can be gated one by one. This gives the usual power-saving states: normal blank with the DAC off, suspend with either sync stopped, and power-down with both syncs stopped.

Top module: `crt_timing_gen`

## Requirements
- R1: A bus write to any register other than the key register (index 0) is dropped unless the key register holds 0x00004758. Writing any other value to the key register locks the bus again.
- R2: All registers read back their stored contents whether the bus is locked or not. The read data is registered and appears one clock after the address. Register indices are: 0 key, 1 generator control, 2 output control, 3 horizontal active/total, 4 horizontal blank, 5 horizontal sync, 6 vertical active/total, 7 vertical blank, 8 vertical sync.
- R3: Each timing register holds (first position − 1) in bits [15:0] and (second position − 1) in bits [31:16]. The x counter runs from 0 up to register 3 bits [31:16] and then returns to 0, advancing y. The y counter returns to 0 after register 6 bits [31:16]. The first pixel shown after enabling is (0,0).
- R4: Sync is active for x in the range (reg5[15:0], reg5[31:16]] and for y in the range (reg8[15:0], reg8[31:16]]. blank_o is high when x is in (reg4[15:0], reg4[31:16]] or y is in (reg7[15:0], reg7[31:16]].
- R5: disp_en_o is high exactly when x ≤ reg3[15:0], y ≤ reg6[15:0] and output-control bit 3 (DAC enable) is set.
- R6: Generator-control bit 0 enables the generator. While it is clear, both counters read 0, disp_en_o and blank_o are low, and both syncs sit at their inactive level.
- R7: Output-control bit 1 enables hsync and bit 2 enables vsync. A disabled sync stays at its inactive level while the other sync keeps running.
- R8: Output-control bit 8 makes hsync active-high and bit 9 makes vsync active-high. When a bit is clear, that sync is active-low.
- R9: After reset the bus is locked, the key register and generator control read 0, and output control reads 0x00010000 (sync-skew field [16:14] = 4). Output control stores only bits 1, 2, 3, 8, 9 and [16:14].
- R10: Timing register writes take effect at the next frame start (pixel (0,0)) while the generator runs, and right away while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| hsync_o | output | 1 | Horizontal sync pin level |
| vsync_o | output | 1 | Vertical sync pin level |
| disp_en_o | output | 1 | Visible-pixel strobe |
| blank_o | output | 1 | Inside a horizontal or vertical blanking window |
| px_x_o | output | 16 | Current pixel column |
| px_y_o | output | 16 | Current pixel row |

## Verification
The hardest case to reach is a timing write that arrives in the middle of a running frame. The old line length has to stay in force up to the last pixel of that frame, and the new one has to start exactly at pixel (0,0). The stimulus waits until the coordinate outputs show the second pixel of a frame, then rewrites the line total and the blank window. A monitor that runs alongside predicts each next coordinate from the old geometry until it sees (0,0), and from the new geometry after that. A generator that switches early or late breaks that chain.

// File: rtl/crt_tg_pkg.sv
package crt_tg_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_4758;
  localparam int NUM_TREGS = 6;
  localparam int TREG_BASE = 3;
  localparam int POS_W     = 16;

  typedef enum logic [3:0] {
    RI_KEY    = 4'd0,
    RI_TGCTL  = 4'd1,
    RI_OUTCTL = 4'd2
  } reg_idx_e;

  // timing register slots (staging/live arrays)
  localparam int TI_HAT = 0;
  localparam int TI_HBL = 1;
  localparam int TI_HSY = 2;
  localparam int TI_VAT = 3;
  localparam int TI_VBL = 4;
  localparam int TI_VSY = 5;

  // output control bit positions
  localparam int OC_HS      = 1;
  localparam int OC_VS      = 2;
  localparam int OC_DAC     = 3;
  localparam int OC_HP      = 8;
  localparam int OC_VP      = 9;
  localparam int OC_SKEW_LO = 14;
  localparam logic [2:0] SKEW_RST = 3'd4;

  typedef struct packed {
    logic hs_en;
    logic vs_en;
    logic dac_en;
    logic hs_pol;
    logic vs_pol;
  } outctl_t;
endpackage

// File: rtl/crt_tg_regs.sv
module crt_tg_regs
  import crt_tg_pkg::*;
#(
  parameter logic [NUM_TREGS*32-1:0] TREG_RST = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [3:0]                   addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  output logic                         tg_en,
  output outctl_t                      oc,
  output logic [NUM_TREGS-1:0][31:0]   treg
);
  logic [31:0] key_q;
  logic        tg_q;
  outctl_t     oc_q;
  logic [2:0]  skew_q;
  logic        wr_ok;
  logic [31:0] oc_word;
  logic [31:0] rd_d;

  assign wr_ok = wr && (key_q == UNLOCK_KEY) && (addr != RI_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      tg_q   <= 1'b0;
      oc_q   <= '0;
      skew_q <= SKEW_RST;
    end else begin
      if (wr && addr == RI_KEY) key_q <= wdata;
      if (wr_ok && addr == RI_TGCTL) tg_q <= wdata[0];
      if (wr_ok && addr == RI_OUTCTL) begin
        oc_q.hs_en  <= wdata[OC_HS];
        oc_q.vs_en  <= wdata[OC_VS];
        oc_q.dac_en <= wdata[OC_DAC];
        oc_q.hs_pol <= wdata[OC_HP];
        oc_q.vs_pol <= wdata[OC_VP];
        skew_q      <= wdata[OC_SKEW_LO +: 3];
      end
    end
  end

  for (genvar gi = 0; gi < NUM_TREGS; gi++) begin : g_treg
    always_ff @(posedge clk) begin
      if (rst) treg[gi] <= TREG_RST[gi*32 +: 32];
      else if (wr_ok && addr == 4'(TREG_BASE + gi)) treg[gi] <= wdata;
    end
  end

  always_comb begin
    oc_word = '0;
    oc_word[OC_HS]  = oc_q.hs_en;
    oc_word[OC_VS]  = oc_q.vs_en;
    oc_word[OC_DAC] = oc_q.dac_en;
    oc_word[OC_HP]  = oc_q.hs_pol;
    oc_word[OC_VP]  = oc_q.vs_pol;
    oc_word[OC_SKEW_LO +: 3] = skew_q;
    rd_d = '0;
    if (addr == RI_KEY)    rd_d = key_q;
    if (addr == RI_TGCTL)  rd_d = {31'd0, tg_q};
    if (addr == RI_OUTCTL) rd_d = oc_word;
    for (int i = 0; i < NUM_TREGS; i++)
      if (addr == 4'(TREG_BASE + i)) rd_d = treg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  assign tg_en = tg_q;
  assign oc    = oc_q;

  // R1: a write while locked leaves control state untouched
  assert_locked_write_dropped_R1: assert property (@(posedge clk) disable iff (rst)
    (wr && addr != RI_KEY && key_q != UNLOCK_KEY) |=> ($stable(tg_q) && $stable(oc_q) && $stable(treg)));
endmodule

// File: rtl/crt_tg_raster.sv
module crt_tg_raster
  import crt_tg_pkg::*;
#(
  parameter logic [NUM_TREGS*32-1:0] TREG_RST = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [NUM_TREGS-1:0][31:0] staged,
  output logic [NUM_TREGS-1:0][31:0] live,
  output logic [POS_W-1:0]           hcnt,
  output logic [POS_W-1:0]           vcnt
);
  logic [POS_W-1:0] h_last;
  logic [POS_W-1:0] v_last;
  logic             line_end;
  logic             frame_end;

  assign h_last    = live[TI_HAT][31:16];
  assign v_last    = live[TI_VAT][31:16];
  assign line_end  = (hcnt >= h_last);
  assign frame_end = line_end && (vcnt >= v_last);

  // shadow copy: reloaded only at frame wrap or while stopped
  always_ff @(posedge clk) begin
    if (rst)                   live <= TREG_RST;
    else if (!en || frame_end) live <= staged;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= (vcnt >= v_last) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assert_hcnt_in_line_R3: assert property (@(posedge clk) disable iff (rst)
    hcnt <= h_last);
  assert_stopped_holds_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hcnt == '0 && vcnt == '0));
  assert_live_stable_midframe_R10: assert property (@(posedge clk) disable iff (rst)
    (hcnt != '0 || vcnt != '0) |-> $stable(live));
endmodule

// File: rtl/crt_tg_outstage.sv
module crt_tg_outstage
  import crt_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  outctl_t          oc,
  input  logic [POS_W-1:0] hcnt,
  input  logic [POS_W-1:0] vcnt,
  input  logic [POS_W-1:0] h_act_m1,
  input  logic [POS_W-1:0] h_bl_lo,
  input  logic [POS_W-1:0] h_bl_hi,
  input  logic [POS_W-1:0] h_sy_lo,
  input  logic [POS_W-1:0] h_sy_hi,
  input  logic [POS_W-1:0] v_act_m1,
  input  logic [POS_W-1:0] v_bl_lo,
  input  logic [POS_W-1:0] v_bl_hi,
  input  logic [POS_W-1:0] v_sy_lo,
  input  logic [POS_W-1:0] v_sy_hi,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             disp_en_o,
  output logic             blank_o,
  output logic [POS_W-1:0] px_x_o,
  output logic [POS_W-1:0] px_y_o
);
  function automatic logic in_win(input logic [POS_W-1:0] p, lo_m1, hi_m1);
    return (p > lo_m1) && (p <= hi_m1);
  endfunction

  logic hs_win, vs_win, bl_win, vis;

  assign hs_win = in_win(hcnt, h_sy_lo, h_sy_hi) && oc.hs_en;
  assign vs_win = in_win(vcnt, v_sy_lo, v_sy_hi) && oc.vs_en;
  assign bl_win = in_win(hcnt, h_bl_lo, h_bl_hi) || in_win(vcnt, v_bl_lo, v_bl_hi);
  assign vis    = (hcnt <= h_act_m1) && (vcnt <= v_act_m1) && oc.dac_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o   <= 1'b1;
      vsync_o   <= 1'b1;
      disp_en_o <= 1'b0;
      blank_o   <= 1'b0;
      px_x_o    <= '0;
      px_y_o    <= '0;
    end else begin
      hsync_o   <= (en && hs_win) ? oc.hs_pol : !oc.hs_pol;
      vsync_o   <= (en && vs_win) ? oc.vs_pol : !oc.vs_pol;
      disp_en_o <= en && vis;
      blank_o   <= en && bl_win;
      px_x_o    <= en ? hcnt : '0;
      px_y_o    <= en ? vcnt : '0;
    end
  end

  assert_visible_needs_dac_R5: assert property (@(posedge clk) disable iff (rst)
    disp_en_o |-> $past(oc.dac_en));
  assert_hsync_gated_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !oc.hs_en |=> (hsync_o == !$past(oc.hs_pol)));
  assert_vsync_gated_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !oc.vs_en |=> (vsync_o == !$past(oc.vs_pol)));
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_tg_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        disp_en_o,
  output logic        blank_o,
  output logic [15:0] px_x_o,
  output logic [15:0] px_y_o
);
  localparam int H_SS  = H_ACTIVE + H_FRONT;
  localparam int H_SE  = H_SS + H_SYNC;
  localparam int H_TOT = H_SE + H_BACK;
  localparam int V_SS  = V_ACTIVE + V_FRONT;
  localparam int V_SE  = V_SS + V_SYNC;
  localparam int V_TOT = V_SE + V_BACK;
  localparam logic [NUM_TREGS*32-1:0] TREG_RST = {
    16'(V_SE - 1),  16'(V_SS - 1),
    16'(V_TOT - 1), 16'(V_ACTIVE - 1),
    16'(V_TOT - 1), 16'(V_ACTIVE - 1),
    16'(H_SE - 1),  16'(H_SS - 1),
    16'(H_TOT - 1), 16'(H_ACTIVE - 1),
    16'(H_TOT - 1), 16'(H_ACTIVE - 1)
  };

  logic                       tg_en;
  outctl_t                    oc;
  logic [NUM_TREGS-1:0][31:0] staged;
  logic [NUM_TREGS-1:0][31:0] live;
  logic [POS_W-1:0]           hcnt, vcnt;

  crt_tg_regs #(.TREG_RST(TREG_RST)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .tg_en(tg_en), .oc(oc), .treg(staged)
  );

  crt_tg_raster #(.TREG_RST(TREG_RST)) u_raster (
    .clk(clk), .rst(rst), .en(tg_en), .staged(staged), .live(live),
    .hcnt(hcnt), .vcnt(vcnt)
  );

  crt_tg_outstage u_out (
    .clk(clk), .rst(rst), .en(tg_en), .oc(oc), .hcnt(hcnt), .vcnt(vcnt),
    .h_act_m1(live[TI_HAT][15:0]),
    .h_bl_lo(live[TI_HBL][15:0]), .h_bl_hi(live[TI_HBL][31:16]),
    .h_sy_lo(live[TI_HSY][15:0]), .h_sy_hi(live[TI_HSY][31:16]),
    .v_act_m1(live[TI_VAT][15:0]),
    .v_bl_lo(live[TI_VBL][15:0]), .v_bl_hi(live[TI_VBL][31:16]),
    .v_sy_lo(live[TI_VSY][15:0]), .v_sy_hi(live[TI_VSY][31:16]),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .disp_en_o(disp_en_o),
    .blank_o(blank_o), .px_x_o(px_x_o), .px_y_o(px_y_o)
  );
endmodule

// File: tb/test_crt_timing_gen.sv
module test_crt_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hsync_o, vsync_o, disp_en_o, blank_o;
  logic [15:0] px_x_o, px_y_o;

  always #5 clk = ~clk;

  crt_timing_gen #(
    .H_ACTIVE(6), .H_FRONT(2), .H_SYNC(3), .H_BACK(2),
    .V_ACTIVE(4), .V_FRONT(1), .V_SYNC(2), .V_BACK(1)
  ) i_crt_timing_gen (.*);

  typedef struct packed {
    logic [7:0] ha, hf, hs, hb, va, vf, vs, vb;
    logic hse, vse, dac, hp, vp;
  } vec_t;

  // rows: unblank, normal blank, vsync suspend, hsync suspend, power down
  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'd6, 8'd2, 8'd3, 8'd2, 8'd4, 8'd1, 8'd2, 8'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'd5, 8'd1, 8'd2, 8'd3, 8'd3, 8'd2, 8'd1, 8'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'd8, 8'd3, 8'd1, 8'd1, 8'd5, 8'd1, 8'd1, 8'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'd4, 8'd1, 8'd4, 8'd1, 8'd2, 8'd1, 8'd3, 8'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'd6, 8'd2, 8'd2, 8'd2, 8'd3, 8'd1, 8'd1, 8'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic int htot(input vec_t c); return c.ha + c.hf + c.hs + c.hb; endfunction
  function automatic int vtot(input vec_t c); return c.va + c.vf + c.vs + c.vb; endfunction
  function automatic logic [31:0] pack2(input int a, input int b);
    return {16'(b - 1), 16'(a - 1)};
  endfunction

  task automatic program_cfg(input vec_t c);
    bus_write(4'd3, pack2(c.ha, htot(c)));
    bus_write(4'd4, pack2(c.ha, htot(c)));
    bus_write(4'd5, pack2(c.ha + c.hf, c.ha + c.hf + c.hs));
    bus_write(4'd6, pack2(c.va, vtot(c)));
    bus_write(4'd7, pack2(c.va, vtot(c)));
    bus_write(4'd8, pack2(c.va + c.vf, c.va + c.vf + c.vs));
    bus_write(4'd2, {15'd0, 3'd4, 4'd0, c.vp, c.hp, 4'd0, c.dac, c.vse, c.hse, 1'b0});
  endtask

  // running monitor: coordinate chain plus window checks
  logic mon_on = 1'b0;
  logic pending = 1'b0;
  logic have_prev = 1'b0;
  vec_t cfg_cur, cfg_next;
  int   prev_x, prev_y;

  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (!mon_on) begin
        have_prev = 1'b0;
      end else begin
        int ex, ey, x, y, hss, hse, vss, vse;
        logic hw, vw;
        x = px_x_o; y = px_y_o;
        if (!have_prev) begin
          ex = 0; ey = 0;
        end else if (prev_x == htot(cfg_cur) - 1) begin
          ex = 0;
          ey = (prev_y == vtot(cfg_cur) - 1) ? 0 : prev_y + 1;
        end else begin
          ex = prev_x + 1; ey = prev_y;
        end
        check("R3 x sequence", 32'(x), 32'(ex));
        check("R3 y sequence", 32'(y), 32'(ey));
        have_prev = 1'b1; prev_x = x; prev_y = y;
        if (pending && x == 0 && y == 0) begin
          cfg_cur = cfg_next; pending = 1'b0;   // R10 switch at frame start
        end
        hss = cfg_cur.ha + cfg_cur.hf; hse = hss + cfg_cur.hs;
        vss = cfg_cur.va + cfg_cur.vf; vse = vss + cfg_cur.vs;
        hw = (x >= hss) && (x < hse);
        vw = (y >= vss) && (y < vse);
        check("R4/R7/R8 hsync", 32'(hsync_o), 32'((cfg_cur.hse && hw) ? cfg_cur.hp : !cfg_cur.hp));
        check("R4/R7/R8 vsync", 32'(vsync_o), 32'((cfg_cur.vse && vw) ? cfg_cur.vp : !cfg_cur.vp));
        check("R4 blank", 32'(blank_o), 32'((x >= cfg_cur.ha) || (y >= cfg_cur.va)));
        check("R5 disp_en", 32'(disp_en_o),
              32'((x < cfg_cur.ha) && (y < cfg_cur.va) && cfg_cur.dac));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state and R2 readback while locked
    bus_read(4'd0, rd); check("R9 key reset", rd, 32'h0);
    bus_read(4'd1, rd); check("R9 tgctl reset", rd, 32'h0);
    bus_read(4'd2, rd); check("R9 outctl reset", rd, 32'h0001_0000);
    bus_read(4'd3, rd); check("R2 R9 hreg default", rd, {16'd12, 16'd5});
    bus_read(4'd8, rd); check("R2 R9 vsync reg default", rd, {16'd6, 16'd4});

    // R1 locked write dropped
    bus_write(4'd1, 32'h1);
    repeat (3) @(negedge clk);
    check("R1 locked enable ignored x", 32'(px_x_o), 32'h0);
    check("R1 locked enable ignored disp", 32'(disp_en_o), 32'h0);
    bus_read(4'd1, rd); check("R1 locked tgctl readback", rd, 32'h0);

    // unlock, check storage mask
    bus_write(4'd0, 32'h0000_4758);
    bus_read(4'd0, rd); check("R2 key readback", rd, 32'h0000_4758);
    bus_write(4'd2, 32'hFFFF_FFFF);
    bus_read(4'd2, rd); check("R9 outctl mask", rd, 32'h0001_C30E);
    // relock, then write must be dropped
    bus_write(4'd0, 32'h0000_0001);
    bus_write(4'd2, 32'h0);
    bus_read(4'd2, rd); check("R1 relock outctl kept", rd, 32'h0001_C30E);
    bus_write(4'd3, 32'h0);
    bus_read(4'd3, rd); check("R1 relock timing kept", rd, {16'd12, 16'd5});
    bus_write(4'd0, 32'h0000_4758);

    // table walk
    for (int v = 0; v < NV; v++) begin
      bus_write(4'd1, 32'h0);
      program_cfg(VECS[v]);
      cfg_cur = VECS[v];
      bus_write(4'd1, 32'h1);
      mon_on = 1'b1;
      repeat (2 * htot(VECS[v]) * vtot(VECS[v]) + 5) @(negedge clk);
      mon_on = 1'b0;
    end

    // R10 mid-frame timing change
    begin
      vec_t nc;
      bus_write(4'd1, 32'h0);
      program_cfg(VECS[0]);
      cfg_cur = VECS[0];
      bus_write(4'd1, 32'h1);
      mon_on = 1'b1;
      @(negedge clk);
      while (!(px_x_o == 16'd1 && px_y_o == 16'd0)) @(negedge clk);
      nc = VECS[0];
      nc.hb = 8'd5;
      bus_write(4'd3, pack2(nc.ha, htot(nc)));
      bus_write(4'd4, pack2(nc.ha, htot(nc)));
      cfg_next = nc;
      pending = 1'b1;
      repeat (htot(VECS[0]) * vtot(VECS[0]) + 2 * htot(nc) * vtot(nc)) @(negedge clk);
      check("R10 new frame geometry taken", 32'(pending), 32'h0);
      mon_on = 1'b0;
    end

    // R6 disable while running
    bus_write(4'd1, 32'h0);
    @(negedge clk);
    check("R6 stopped x", 32'(px_x_o), 32'h0);
    check("R6 stopped y", 32'(px_y_o), 32'h0);
    check("R6 stopped disp_en", 32'(disp_en_o), 32'h0);
    check("R6 stopped blank", 32'(blank_o), 32'h0);
    check("R6 R8 hsync idle (active-high)", 32'(hsync_o), 32'h0);
    check("R6 R8 vsync idle (active-low)", 32'(vsync_o), 32'h1);
    repeat (5) @(negedge clk);
    check("R6 still held x", 32'(px_x_o), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule